// File: doc/BRIEF.md
# Daisy-Chained Serial Converter Write Controller

This block is the host-side master for a string of serial-input 16-bit digital-to-analog converters. All converters share one serial clock line and one active-low enable line that also acts as the load strobe. Each device's data output feeds the data input of the next device. A request carries one 16-bit code per device. The controller shifts the whole concatenated stream in one continuous burst, then raises the enable line so that every device moves its shift-register contents into its output register on the same edge.

All serial timing is counted in system clock cycles through parameters: enable-low to first clock rise, clock high time, clock low time, the gap from the last clock rise to the load edge, and the load pulse width. The serial clock idles low and is always low when the enable line changes. With readback enabled, the controller samples the chain's far-end serial output on every clock rise and compares the bits with the stream it wrote last time. After reset the expected stream is all zeros.

A request is accepted through a valid/ready port. Ready stays low from acceptance until the load pulse ends. A one-cycle done pulse marks completion, and the mismatch flag is valid from that cycle on.

Top module: `sdac_chain_ctrl`

## Requirements
- R1: While reset is asserted and after it: `dac_en_n` is 1, `dac_sclk` is 0, `req_ready` is 1, `done` is 0 and `mismatch` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 whenever `dac_en_n` is 0 and through the load pulse. `done` is 1 for exactly one cycle, and `req_ready` is 1 in that cycle.
- R3: `dac_en_n` falls one cycle after acceptance, only while `dac_sclk` has been 0 for at least one cycle. `dac_sclk` is 1 only while `dac_en_n` is 0. The first rise of `dac_sclk` comes exactly T_LEAD cycles after `dac_en_n` falls.
- R4: Each high phase of `dac_sclk` lasts exactly T_HIGH cycles, and each low phase between two rises lasts exactly T_LOW cycles. Each transfer has exactly N_DEV*16 rises.
- R5: `req_data[16k+15:16k]` is the code for device k, where device 0 is nearest the controller. The serial stream is word N_DEV-1 first and word 0 last, each word most significant bit first. `dac_sdo` changes only in the cycle `dac_sclk` falls and is stable while `dac_sclk` is high.
- R6: `dac_en_n` rises exactly T_HIGH+T_TAIL cycles after the last rise of `dac_sclk`, with `dac_sclk` low.
- R7: `dac_en_n` stays high for T_LOAD cycles before `done`. Every device's output register then holds its word from the request.
- R8: `dac_sdi` is sampled at each rise of `dac_sclk` and compared with the previous transfer's stream, which is all zeros after reset. `mismatch` clears on acceptance, becomes 1 if any sampled bit differs, and holds until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request carries a full set of codes |
| req_ready | output | 1 | Controller idle and able to accept |
| req_data | input | N_DEV*16 | One 16-bit code per device, device 0 in the low word |
| dac_sclk | output | 1 | Serial clock to all devices |
| dac_sdo | output | 1 | Serial data to the nearest device |
| dac_en_n | output | 1 | Shared enable, active low; rising edge loads all devices |
| dac_sdi | input | 1 | Serial output of the farthest device |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Readback differed from the previous stream |

## Verification
`dac_en_n` falls one cycle after acceptance. The first clock rise follows T_LEAD cycles later, each bit then takes T_HIGH+T_LOW cycles, the load edge comes T_HIGH+T_TAIL cycles after the last rise, and `done` comes T_LOAD cycles after that. The bench samples every output at the falling system clock edge and counts the run length of each phase in samples. Each length is compared with its parameter at the sample where the level changes. Data and readback results are checked at the `done` sample against a behavioural chain model: the model's shift registers must equal the request, and `mismatch` is predicted from the model's contents against the previous request, or forced by inverting the returned bits.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_TAIL = 3'd4,
    ST_LOAD = 3'd5
  } sdac_state_e;

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_timer.sv
module sdac_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq
  import sdac_pkg::*;
#(
  parameter int NB     = 32,
  parameter int BCW    = 6,
  parameter int CW     = 4,
  parameter int T_LEAD = 2,
  parameter int T_HIGH = 3,
  parameter int T_LOW  = 2,
  parameter int T_TAIL = 4,
  parameter int T_LOAD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          sclk,
  output logic          en_n,
  output logic          done,
  output logic          accept,
  output logic          sample,
  output logic          rotate
);

  sdac_state_e    state_q, state_d;
  logic [BCW-1:0] bits_q, bits_d;
  logic           sclk_q, sclk_d, en_n_q, en_n_d, done_q, done_d;

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    sample   = 1'b0;
    rotate   = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        state_d  = ST_LEAD;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_LEAD - 1);
        bits_d   = BCW'(NB);
      end
      ST_LEAD, ST_LOW: if (expired) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_HIGH - 1);
        sample   = 1'b1;
        bits_d   = bits_q - BCW'(1);
      end
      ST_HIGH: if (expired) begin
        rotate   = 1'b1;
        tmr_load = 1'b1;
        if (bits_q == '0) begin
          state_d = ST_TAIL;
          tmr_val = CW'(T_TAIL - 1);
        end else begin
          state_d = ST_LOW;
          tmr_val = CW'(T_LOW - 1);
        end
      end
      ST_TAIL: if (expired) begin
        state_d  = ST_LOAD;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_LOAD - 1);
      end
      ST_LOAD: if (expired) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    sclk_d = (state_d == ST_HIGH);
    en_n_d = (state_d == ST_IDLE) || (state_d == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      sclk_q  <= 1'b0;
      en_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      sclk_q  <= sclk_d;
      en_n_q  <= en_n_d;
      done_q  <= done_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign sclk      = sclk_q;
  assign en_n      = en_n_q;
  assign done      = done_q;

endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
  parameter int NB      = 32,
  parameter bit RDBK_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [NB-1:0] load_data,
  input  logic          rotate,
  input  logic          sample,
  input  logic          sdi,
  output logic          sdo,
  output logic          mismatch
);

  logic [NB-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (accept)
      out_d = load_data;
    else if (rotate)
      out_d = {out_q[NB-2:0], out_q[NB-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign sdo = out_q[NB-1];

  generate
    if (RDBK_EN) begin : g_rdbk
      logic [NB-1:0] exp_q, exp_d;
      logic          mis_q, mis_d;

      always_comb begin
        exp_d = exp_q;
        mis_d = mis_q;
        if (accept) begin
          exp_d = out_q;
          mis_d = 1'b0;
        end else begin
          if (rotate)
            exp_d = {exp_q[NB-2:0], exp_q[NB-1]};
          if (sample && (sdi != exp_q[NB-1]))
            mis_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          exp_q <= '0;
          mis_q <= 1'b0;
        end else begin
          exp_q <= exp_d;
          mis_q <= mis_d;
        end
      end

      assign mismatch = mis_q;
    end else begin : g_no_rdbk
      logic unused_rdbk;
      assign unused_rdbk = sdi ^ sample;
      assign mismatch    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sdac_chain_ctrl.sv
module sdac_chain_ctrl
  import sdac_pkg::*;
#(
  parameter int N_DEV   = 2,
  parameter int WORD_W  = 16,
  parameter int T_LEAD  = 2,
  parameter int T_HIGH  = 3,
  parameter int T_LOW   = 2,
  parameter int T_TAIL  = 4,
  parameter int T_LOAD  = 3,
  parameter bit RDBK_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [N_DEV*WORD_W-1:0] req_data,
  output logic                    dac_sclk,
  output logic                    dac_sdo,
  output logic                    dac_en_n,
  input  logic                    dac_sdi,
  output logic                    done,
  output logic                    mismatch
);

  localparam int NB   = N_DEV * WORD_W;
  localparam int BCW  = $clog2(NB + 1);
  localparam int TMAX = max_of2(max_of2(max_of2(T_LEAD, T_HIGH), max_of2(T_LOW, T_TAIL)), T_LOAD);
  localparam int CW   = $clog2(TMAX + 1);

  logic          tmr_load, expired, accept, sample, rotate;
  logic [CW-1:0] tmr_val;

  sdac_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .val     (tmr_val),
    .expired (expired)
  );

  sdac_seq #(
    .NB(NB), .BCW(BCW), .CW(CW),
    .T_LEAD(T_LEAD), .T_HIGH(T_HIGH), .T_LOW(T_LOW),
    .T_TAIL(T_TAIL), .T_LOAD(T_LOAD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .expired   (expired),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .sclk      (dac_sclk),
    .en_n      (dac_en_n),
    .done      (done),
    .accept    (accept),
    .sample    (sample),
    .rotate    (rotate)
  );

  sdac_shreg #(.NB(NB), .RDBK_EN(RDBK_EN)) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .load_data (req_data),
    .rotate    (rotate),
    .sample    (sample),
    .sdi       (dac_sdi),
    .sdo       (dac_sdo),
    .mismatch  (mismatch)
  );

endmodule

// File: rtl/sdac_chain_ctrl_chk.sv
module sdac_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic dac_sclk,
  input logic dac_sdo,
  input logic dac_en_n,
  input logic done,
  input logic mismatch
);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en_n |-> !req_ready);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_en_fall_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_en_n) |-> (!dac_sclk && !$past(dac_sclk)));

  p_sclk_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> !dac_en_n);

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

  p_load_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_en_n) |-> !dac_sclk);

  p_mis_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_en_n && $past(dac_en_n) && !$past(req_valid && req_ready)) |-> $stable(mismatch));

endmodule

bind sdac_chain_ctrl sdac_chain_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dac_sclk  (dac_sclk),
  .dac_sdo   (dac_sdo),
  .dac_en_n  (dac_en_n),
  .done      (done),
  .mismatch  (mismatch)
);

// File: tb/sdac_chain_ctrl_test.sv
`timescale 1ns/1ps
module sdac_chain_ctrl_test;

  localparam int N_DEV  = 2;
  localparam int NB     = N_DEV * 16;
  localparam int T_LEAD = 2;
  localparam int T_HIGH = 3;
  localparam int T_LOW  = 2;
  localparam int T_TAIL = 4;
  localparam int T_LOAD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [NB-1:0] req_data = '0;
  logic          req_ready, dac_sclk, dac_sdo, dac_en_n, done, mismatch;
  logic          dac_sdi;

  logic [NB-1:0] chain = '0;
  logic [NB-1:0] latched = '0;
  logic          inj = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdac_chain_ctrl #(
    .N_DEV(N_DEV), .WORD_W(16), .T_LEAD(T_LEAD), .T_HIGH(T_HIGH),
    .T_LOW(T_LOW), .T_TAIL(T_TAIL), .T_LOAD(T_LOAD), .RDBK_EN(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .dac_en_n(dac_en_n), .dac_sdi(dac_sdi), .done(done), .mismatch(mismatch)
  );

  // behavioural chain: nearest device in chain[15:0], far-end output at MSB
  assign dac_sdi = chain[NB-1] ^ inj;
  always @(posedge dac_sclk) if (!dac_en_n) chain <= {chain[NB-2:0], dac_sdo};
  always @(posedge dac_en_n) latched <= chain;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // phase-length monitor, sampled at the falling system clock edge
  bit mon_on = 1'b0;
  logic ps = 1'b0, pc = 1'b1, pd = 1'b0, psdo = 1'b0;
  int hi_run = 0, lo_run = 0, since = 0, nrise = 0, ld_run = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (dac_sclk) hi_run++;
      if (!dac_sclk && !dac_en_n) lo_run++;
      if (ps && !dac_sclk) begin
        chk(hi_run == T_HIGH, "R4 high time", 64'(hi_run), 64'(T_HIGH));
        hi_run = 0;
      end
      if (!ps && dac_sclk) begin
        if (nrise == 0) chk(lo_run == T_LEAD, "R3 lead time", 64'(lo_run), 64'(T_LEAD));
        else            chk(lo_run == T_LOW, "R4 low time", 64'(lo_run), 64'(T_LOW));
        lo_run = 0;
        since  = 1;
        nrise++;
      end else if (!dac_en_n) begin
        since++;
      end
      if (pc && !dac_en_n)
        chk(!dac_sclk && !ps, "R3 clock low at enable fall", 64'(dac_sclk), 64'd0);
      if (!pc && dac_en_n) begin
        chk(since == T_HIGH + T_TAIL, "R6 last rise to load", 64'(since), 64'(T_HIGH + T_TAIL));
        chk(!dac_sclk, "R6 clock low at load", 64'(dac_sclk), 64'd0);
        chk(nrise == NB, "R4 rise count", 64'(nrise), 64'(NB));
        nrise = 0;
        lo_run = 0;
      end
      if (dac_en_n && !req_ready) ld_run++;
      if (done) begin
        chk(ld_run == T_LOAD, "R7 load width", 64'(ld_run), 64'(T_LOAD));
        chk(req_ready, "R2 ready with done", 64'(req_ready), 64'd1);
        ld_run = 0;
      end
      if (pd) chk(!done, "R2 done one cycle", 64'(done), 64'd0);
      if (!dac_en_n) chk(!req_ready, "R2 busy not ready", 64'(req_ready), 64'd0);
      if (dac_sclk) chk(!dac_en_n, "R3 clock gated", 64'(dac_en_n), 64'd0);
      if (ps && dac_sclk) chk(dac_sdo == psdo, "R5 data held while high", 64'(dac_sdo), 64'(psdo));
      ps = dac_sclk; pc = dac_en_n; pd = done; psdo = dac_sdo;
    end
  end

  logic [NB-1:0] last_sent = '0;

  task automatic send(input logic [NB-1:0] data, input bit bad);
    bit exp_mis;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_mis   = bad || (chain != last_sent);
    inj       = bad;
    req_valid = 1'b1;
    req_data  = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready drops on accept", 64'(req_ready), 64'd0);
    chk(!dac_en_n, "R3 enable falls after accept", 64'(dac_en_n), 64'd0);
    while (!done) @(negedge clk);
    chk(chain == data, "R5 chain contents", 64'(chain), 64'(data));
    chk(latched == data, "R7 devices loaded", 64'(latched), 64'(data));
    chk(mismatch == exp_mis, "R8 readback flag", 64'(mismatch), 64'(exp_mis));
    last_sent = data;
    inj = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dac_en_n == 1'b1, "R1 enable idle", 64'(dac_en_n), 64'd1);
    chk(dac_sclk == 1'b0, "R1 clock idle", 64'(dac_sclk), 64'd0);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && mismatch == 1'b0, "R1 flags", 64'({done, mismatch}), 64'd0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(dac_en_n && !dac_sclk && req_ready, "R1 after release",
        64'({dac_en_n, dac_sclk, req_ready}), 64'b101);

    send('0, 1'b0);
    for (int i = 0; i < NB; i++) send(NB'(1) << i, 1'b0);
    send('1, 1'b0);
    send(32'hA5C3_5A3C, 1'b0);
    send(32'h8000_0001, 1'b1);
    repeat (5) @(negedge clk);
    chk(mismatch == 1'b1, "R8 flag held while idle", 64'(mismatch), 64'd1);
    send(32'h1234_FEDC, 1'b0);
    send(32'h0F0F_F0F0, 1'b1);
    send(32'h0000_FFFF, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule